// File: doc/BRIEF.md
# RZI Infrared Bit Modem

This block sits between a serial frame layer and an infrared transceiver. On the transmit side it takes one bit at a time through a valid/ready handshake. A zero becomes a short light pulse at the start of the bit cell. A one leaves the emitter dark for the whole cell. On the receive side it synchronizes the photodetector output and finds the rising edge of each pulse. It rebuilds the bit cells around those edges and delivers one decoded bit per cell.

Both directions share one line-rate select: a fast rate and a slow rate at half of it. A bit cell is a fixed number of sample ticks, and an integer clock divider that the rate select chooses sets the tick spacing. Flags, bit stuffing, CRC and address matching are the job of the frame layer above this block.

Top module: `rzi_ir_modem`

## Requirements
- R1: A bit cell lasts 8 sample ticks; a tick is DIV_FAST clocks when `rate_fast` is 1 and DIV_SLOW clocks when it is 0 (defaults 2 and 4, giving cells of 16 and 32 clocks, a 2:1 rate ratio).
- R2: A zero accepted at a clock edge drives `ir_out` to 1 (light) from the next cycle for exactly one quarter of the cell (2 ticks), then to 0 for the rest of the cell.
- R3: A one accepted at a clock edge keeps `ir_out` at 0 for the whole cell.
- R4: `tx_ready` is 1 while no bit is in flight and during the last clock of the cell in flight, and 0 otherwise. A bit is taken on an edge where `tx_valid` and `tx_ready` are both 1. Bits go out in the order they are accepted, with no gap when the next bit is offered on time.
- R5: With no bit in flight, `ir_out` is 0.
- R6: `ir_in` (1 = light) passes through a two-flop synchronizer. The receiver emits nothing until it sees its first rising light edge, and each such edge marks the cell it starts as a zero.
- R7: A cell with no light edge decodes as one. Each decoded cell raises `rx_valid` for exactly one cycle with the bit on `rx_bit`, and bits come out in line order.
- R8: Each light edge restarts the cell timing. An edge that arrives in the second half of a cell closes that cell early. An edge in the first half realigns the current cell. This lets a stream whose bit period differs from the nominal one by one clock per cell decode correctly.
- R9: After 8 consecutive decoded ones the receiver falls silent and emits nothing more until the next light edge.
- R10: After reset `tx_ready` is 1, `ir_out` is 0 and `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_fast | input | 1 | 1 selects the fast line rate, 0 the slow one |
| tx_valid | input | 1 | A transmit bit is offered |
| tx_bit | input | 1 | The transmit bit value |
| tx_ready | output | 1 | The offered bit will be taken on this edge |
| ir_out | output | 1 | Emitter drive, 1 = light |
| ir_in | input | 1 | Asynchronous detector input, 1 = light |
| rx_valid | output | 1 | One-cycle strobe per decoded bit |
| rx_bit | output | 1 | Decoded bit value |

## Verification
A table of bytes, each paired with a rate, is sent bit by bit. For every cell the bench measures pulse length, pulse start and ready timing, which separates zero from one coding and fast from slow cell length. The transmitter output is looped into the receiver. Bytes that start with ones, hold only ones, hold only zeros, or end in long runs of ones show leading-one suppression, back-to-back pulses and the idle cutoff. Directed streams whose bit period is one clock long or one clock short show whether the edge-driven realignment closes cells early or realigns them as R8 states.

// File: rtl/rzi_pkg.sv
package rzi_pkg;

    // Sample ticks per bit cell and the derived pulse and counter widths.
    localparam int SPB       = 8;
    localparam int PH_W      = $clog2(SPB);
    localparam int QUARTER   = SPB / 4;
    localparam int IDLE_ONES = 8;
    localparam int ONES_W    = $clog2(IDLE_ONES);

    typedef struct packed {
        logic            busy;
        logic            data;
        logic [PH_W-1:0] phase;
    } tx_state_t;

    typedef struct packed {
        logic [1:0]        sync;
        logic              prev;
        logic              active;
        logic              zero;
        logic [PH_W-1:0]   phase;
        logic [ONES_W-1:0] ones;
        logic              valid;
        logic              data;
    } rx_state_t;

endpackage

// File: rtl/rzi_sample_timer.sv
module rzi_sample_timer #(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_fast,
    input  logic clear,
    output logic tick
);
    localparam int CNT_W = $clog2(DIV_SLOW + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q, limit;

    always_comb begin
        limit = rate_fast ? CNT_W'(DIV_FAST - 1) : CNT_W'(DIV_SLOW - 1);
        tick  = (cnt_q >= limit);
        cnt_d = (clear || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (DIV_FAST > 1) begin : g_gap
            // R1: ticks are never adjacent when every divider exceeds one
            a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/rzi_tx.sv
module rzi_tx
    import rzi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic tx_valid,
    input  logic tx_bit,
    output logic tx_ready,
    output logic ir_out,
    output logic clear
);
    tx_state_t s_d, s_q;
    logic last, accept;

    always_comb begin
        s_d      = s_q;
        last     = s_q.busy && tick && (s_q.phase == PH_W'(SPB - 1));
        tx_ready = !s_q.busy || last;
        accept   = tx_valid && tx_ready;
        clear    = accept;
        if (accept) begin
            s_d.busy  = 1'b1;
            s_d.data  = tx_bit;
            s_d.phase = '0;
        end else if (last) begin
            s_d.busy  = 1'b0;
            s_d.phase = '0;
        end else if (s_q.busy && tick) begin
            s_d.phase = s_q.phase + 1'b1;
        end
        ir_out = s_q.busy && !s_q.data && (s_q.phase < PH_W'(QUARTER));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: an accepted zero lights the emitter on the next cycle
    a_r2_zero_lights: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && !tx_bit) |=> ir_out);
    // R3: an accepted one keeps the emitter dark on the next cycle
    a_r3_one_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_bit) |=> !ir_out);
    // R4: the bit in flight cannot change while the port is not ready
    a_r4_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && !tx_ready) |=> $stable(s_q.data));
    // R5: no light without a bit in flight
    a_r5_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.busy && !tx_valid) |=> !ir_out);

endmodule

// File: rtl/rzi_rx.sv
module rzi_rx
    import rzi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ir_in,
    output logic clear,
    output logic rx_valid,
    output logic rx_bit
);
    rx_state_t s_d, s_q;
    logic edge_w, window_end, emit, emit_bit;

    always_comb begin
        s_d        = s_q;
        s_d.sync   = {s_q.sync[0], ir_in};
        s_d.prev   = s_q.sync[1];
        edge_w     = s_q.sync[1] && !s_q.prev;
        window_end = s_q.active && tick && (s_q.phase == PH_W'(SPB - 1));
        emit       = 1'b0;
        emit_bit   = 1'b0;
        clear      = edge_w;
        if (edge_w) begin
            if (s_q.active && (s_q.phase >= PH_W'(SPB / 2))) begin
                emit     = 1'b1;
                emit_bit = !s_q.zero;
            end
            s_d.active = 1'b1;
            s_d.zero   = 1'b1;
            s_d.phase  = '0;
            s_d.ones   = '0;
        end else if (window_end) begin
            emit      = 1'b1;
            emit_bit  = !s_q.zero;
            s_d.phase = '0;
            s_d.zero  = 1'b0;
            if (!emit_bit) begin
                s_d.ones = '0;
            end else if (s_q.ones == ONES_W'(IDLE_ONES - 1)) begin
                s_d.active = 1'b0;
                s_d.ones   = '0;
            end else begin
                s_d.ones = s_q.ones + 1'b1;
            end
        end else if (s_q.active && tick) begin
            s_d.phase = s_q.phase + 1'b1;
        end
        s_d.valid = emit;
        s_d.data  = emit_bit;
        rx_valid  = s_q.valid;
        rx_bit    = s_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R7: each decoded bit is a single-cycle strobe
    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
    // R8: a light edge restarts the cell and arms the receiver
    a_r8_resync: assert property (@(posedge clk) disable iff (!rst_n)
        edge_w |=> (s_q.active && s_q.phase == '0 && s_q.zero));
    // R9: a silent receiver emits nothing until a light edge
    a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.active && !edge_w) |=> !rx_valid);

endmodule

// File: rtl/rzi_ir_modem.sv
module rzi_ir_modem #(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_fast,
    input  logic tx_valid,
    input  logic tx_bit,
    output logic tx_ready,
    output logic ir_out,
    input  logic ir_in,
    output logic rx_valid,
    output logic rx_bit
);
    logic tx_tick, tx_clear, rx_tick, rx_clear;

    rzi_sample_timer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_tx_timer (
        .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast),
        .clear(tx_clear), .tick(tx_tick)
    );

    rzi_sample_timer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_rx_timer (
        .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast),
        .clear(rx_clear), .tick(rx_tick)
    );

    rzi_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tx_tick),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
        .ir_out(ir_out), .clear(tx_clear)
    );

    rzi_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(rx_tick), .ir_in(ir_in),
        .clear(rx_clear), .rx_valid(rx_valid), .rx_bit(rx_bit)
    );

endmodule

// File: tb/tb_rzi_ir_modem.sv
module tb_rzi_ir_modem;
    localparam int DIVF  = 2;
    localparam int DIVS  = 4;
    localparam int CELL  = 8;
    localparam int IDLE  = 8;
    localparam int NVEC  = 8;
    // {rate_fast, byte sent first-bit-first from bit 7}
    localparam logic [8:0] VEC [NVEC] = '{
        9'h1D2, 9'h0D2, 9'h100, 9'h0FF, 9'h1A5, 9'h07E, 9'h181, 9'h03C
    };

    logic clk = 1'b0, rst_n = 1'b0, rate_fast = 1'b1;
    logic tx_valid = 1'b0, tx_bit = 1'b0, loop_en = 1'b1, drv = 1'b0;
    logic tx_ready, ir_out, rx_valid, rx_bit, ir_in;
    int checks = 0, errors = 0;
    logic rx_log [64];
    int rx_n = 0;

    assign ir_in = loop_en ? ir_out : drv;
    always #4 clk = ~clk;

    rzi_ir_modem #(.DIV_FAST(DIVF), .DIV_SLOW(DIVS)) dut (
        .clk(clk), .rst_n(rst_n), .rate_fast(rate_fast),
        .tx_valid(tx_valid), .tx_bit(tx_bit), .tx_ready(tx_ready),
        .ir_out(ir_out), .ir_in(ir_in), .rx_valid(rx_valid), .rx_bit(rx_bit)
    );

    always @(negedge clk) begin
        if (rx_valid && rx_n < 64) begin
            rx_log[rx_n] = rx_bit;
            rx_n++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_log();
        @(posedge clk); #1 rx_n = 0;
    endtask

    // Compare the receive log with a byte sent from its first zero on (R6, R7, R9)
    task automatic check_rx(input logic [7:0] b, input string tag);
        int f = 8, t = 0, n;
        for (int i = 7; i >= 0; i--) if (!b[i] && f == 8) f = 7 - i;
        for (int i = 0; i < 8 && b[i]; i++) t++;
        n = (f == 8) ? 0 : (8 - f) + (IDLE - t);
        check(rx_n == n, {tag, " R9 decoded count"}, rx_n, n);
        for (int i = 0; i < n && i < rx_n; i++) begin
            logic e;
            e = (i < 8 - f) ? b[7 - f - i] : 1'b1;
            check(rx_log[i] == e, {tag, " R7 decoded bit"}, rx_log[i], e);
        end
    endtask

    task automatic send_byte(input logic r, input logic [7:0] b);
        int per, hi, early;
        logic first;
        @(negedge clk);
        rate_fast = r;
        per = CELL * (r ? DIVF : DIVS);
        for (int i = 7; i >= 0; i--) begin
            tx_valid = 1'b1;
            tx_bit   = b[i];
            check(tx_ready == 1'b1, "R4 ready at cell boundary", tx_ready, 1);
            @(posedge clk);
            hi = 0; early = 0; first = 1'b0;
            for (int j = 1; j <= per; j++) begin
                @(negedge clk);
                if (j == 1) begin
                    tx_valid = 1'b0;
                    first = ir_out;
                end
                hi += int'(ir_out);
                if (j < per && tx_ready) early++;
            end
            check(early == 0, "R1 cell length", early, 0);
            if (b[i]) begin
                check(hi == 0, "R3 one stays dark", hi, 0);
            end else begin
                check(hi == per / 4, "R2 zero pulse length", hi, per / 4);
                check(first == 1'b1, "R2 pulse starts next cycle", first, 1);
            end
        end
        for (int j = 0; j < 20; j++) begin
            @(negedge clk);
            if (j == 19) check(ir_out == 1'b0, "R5 idle dark", ir_out, 0);
        end
    endtask

    task automatic drive_rx(input logic [7:0] b, input int per);
        for (int i = 7; i >= 0; i--) begin
            for (int j = 0; j < per; j++) begin
                @(negedge clk);
                drv = !b[i] && (j < 2 * DIVF);
            end
        end
        @(negedge clk); drv = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(tx_ready == 1'b1, "R10 ready after reset", tx_ready, 1);
        check(ir_out == 1'b0, "R10 dark after reset", ir_out, 0);
        check(rx_valid == 1'b0, "R10 no strobe after reset", rx_valid, 0);

        // R6: no light, no decoded bits
        loop_en = 1'b0;
        clear_log();
        repeat (200) @(negedge clk);
        check(rx_n == 0, "R6 silent before first edge", rx_n, 0);
        loop_en = 1'b1;

        for (int v = 0; v < NVEC; v++) begin
            clear_log();
            send_byte(VEC[v][8], VEC[v][7:0]);
            repeat (12 * CELL * DIVS) @(negedge clk);
            check_rx(VEC[v][7:0], "loopback");
        end

        // R8: bit period one clock long, then one clock short
        loop_en = 1'b0;
        rate_fast = 1'b1;
        clear_log();
        drive_rx(8'h49, CELL * DIVF + 1);
        repeat (12 * CELL * DIVF) @(negedge clk);
        check_rx(8'h49, "R8 slow drift");
        clear_log();
        drive_rx(8'h49, CELL * DIVF - 1);
        repeat (12 * CELL * DIVF) @(negedge clk);
        check_rx(8'h49, "R8 fast drift");
        clear_log();
        drive_rx(8'h24, CELL * DIVF - 1);
        repeat (12 * CELL * DIVF) @(negedge clk);
        check_rx(8'h24, "R8 fast drift two");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule